// File: doc/BRIEF.md
# Memory-Mapped Register Accumulator Core

This block is a very small 8-bit processor. It has no register file and no separate program counter. The eight general registers are the lowest eight bytes of one 256-byte memory, and byte 0 holds the program counter. Every instruction is two bytes long. The first byte selects the operation, the addressing mode and a register. The second byte is either data or a memory location. The core supports load, store, add, subtract, AND, OR and XOR. It has one zero flag.

To use the core, hold `run_en` low and load the memory through the host write port. This includes byte 0, which is the start address. After reset is released, raise `run_en`. The core fetches and executes instructions until it decodes the halt operation. It then raises `halted` and stays halted until the next reset. A debug port reads any byte at any time without stalling the core. Because the registers are memory bytes, an absolute operand address below 8 reads or writes a register. A result written to register 0 is a jump.

Each instruction takes three active cycles: fetch the first byte, fetch the second byte and advance the PC, then execute. Cycles with `run_en` low freeze the core in the state it is in.

Top module: `memreg_cpu`

## Requirements
- R1: After `rst_n` is released, the core is in its first fetch state, `halted` is 0 and the zero flag is 0. Reset does not alter memory contents.
- R2: While `run_en` is 0, the core advances no state and writes no memory byte.
- R3: An instruction is fetched in two active cycles: the byte at address mem[0], then the byte at mem[0]+1. In the second cycle, byte 0 is rewritten to mem[0]+2 (mod 256). The instruction executes in the third active cycle.
- R4: First-byte encoding: bits [7:5] are the operation (0 load, 1 store, 2 add, 3 subtract, 4 AND, 5 OR, 6 XOR, 7 halt). Bits [4:3] are the mode (0 immediate, 1 absolute, 2 indirect, 3 conditional). Bits [2:0] are the register number.
- R5: In immediate mode, the operand is the second instruction byte.
- R6: In absolute mode, the operand is the byte at the address given by the second byte. Addresses 0 to 7 reach the registers.
- R7: In indirect mode, the second byte names a byte, and that byte holds the operand's address.
- R8: Conditional mode acts as immediate mode when the zero flag is 1. When the flag is 0, it changes nothing except the PC advance.
- R9: Load, add, subtract, AND, OR and XOR write their 8-bit result to the selected register. Add and subtract wrap modulo 256. The flag is set exactly when the result is 0.
- R10: Store copies the register to the effective address (absolute or indirect mode) and leaves the flag unchanged. Store in immediate or conditional mode writes nothing.
- R11: A result written to register 0 replaces the incremented PC, so it acts as a jump. A register-0 source operand reads the already incremented PC.
- R12: Operation 7 raises `halted` after its execute cycle. The core then stays halted and writes nothing until reset.
- R13: `host_we` writes `host_wdata` to `host_addr` at the clock edge. If the core writes the same byte on that edge, the host write wins. `dbg_rdata` shows mem[`dbg_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Core advances only when high |
| halted | output | 1 | High once a halt operation has executed |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 8 | Host write data |
| dbg_addr | input | 8 | Debug read address |
| dbg_rdata | output | 8 | Memory byte at `dbg_addr` |

## Verification
The bench builds the core with its default data width of 8 and eight registers. At these values, the whole 256-byte space can be swept byte by byte against the reference model after each program. Add and subtract results cross the 0xFF/0x00 wrap. Absolute reads of addresses below 8 exercise registers seen as memory. The programs also cover jumps through register 0, both outcomes of conditional mode, and run-enable pauses in the middle of a program.

// File: rtl/memreg_cpu_pkg.sv
package memreg_cpu_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5,
    OP_XOR   = 3'd6,
    OP_HALT  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    MD_IMM  = 2'd0,
    MD_ABS  = 2'd1,
    MD_IND  = 2'd2,
    MD_COND = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_FETCH_OP  = 2'd0,
    ST_FETCH_ARG = 2'd1,
    ST_EXEC      = 2'd2,
    ST_HALT      = 2'd3
  } state_e;

endpackage

// File: rtl/memreg_cpu_mem.sv
module memreg_cpu_mem #(
  parameter int W   = 8,
  parameter int NRD = 5
) (
  input  logic                   clk,
  input  logic                   host_we,
  input  logic [W-1:0]           host_addr,
  input  logic [W-1:0]           host_wdata,
  input  logic                   core_we,
  input  logic [W-1:0]           core_addr,
  input  logic [W-1:0]           core_wdata,
  input  logic [NRD-1:0][W-1:0]  rd_addr,
  output logic [NRD-1:0][W-1:0]  rd_data,
  output logic [W-1:0]           pc
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] store_q [DEPTH];

  // host write placed last so it wins on an address collision
  always_ff @(posedge clk) begin
    if (core_we) store_q[core_addr] <= core_wdata;
    if (host_we) store_q[host_addr] <= host_wdata;
  end

  for (genvar i = 0; i < NRD; i++) begin : g_rd
    assign rd_data[i] = store_q[rd_addr[i]];
  end

  assign pc = store_q[0];

endmodule

// File: rtl/memreg_cpu_alu.sv
module memreg_cpu_alu
  import memreg_cpu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      default: res = rhs;
    endcase
  end
endmodule

// File: rtl/memreg_cpu_seq.sv
module memreg_cpu_seq
  import memreg_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_en,
  input  logic   halt_op,
  output state_e state
);
  state_e state_nx;

  always_comb begin
    state_nx = state;
    if (run_en) begin
      unique case (state)
        ST_FETCH_OP:  state_nx = ST_FETCH_ARG;
        ST_FETCH_ARG: state_nx = ST_EXEC;
        ST_EXEC:      state_nx = halt_op ? ST_HALT : ST_FETCH_OP;
        default:      state_nx = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH_OP;
    else        state <= state_nx;
  end

  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH_OP && run_en) |=> state == ST_FETCH_ARG); // R3

  AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(state)); // R2

endmodule

// File: rtl/memreg_cpu.sv
module memreg_cpu
  import memreg_cpu_pkg::*;
#(
  parameter int W    = 8,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  output logic         halted,
  input  logic         host_we,
  input  logic [W-1:0] host_addr,
  input  logic [W-1:0] host_wdata,
  input  logic [W-1:0] dbg_addr,
  output logic [W-1:0] dbg_rdata
);
  localparam int RSEL_W = $clog2(NREG);
  localparam int NRD    = 5;
  localparam int RP_FETCH = 0, RP_ABS = 1, RP_IND = 2, RP_REG = 3, RP_DBG = 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  state_e               state;
  logic [W-1:0]         ir_op_q, ir_arg_q, ir_op_nx, ir_arg_nx;
  logic                 flag_q, flag_nx;
  logic [W-1:0]         pc;
  logic [NRD-1:0][W-1:0] rd_addr, rd_data;
  logic                 core_we;
  logic [W-1:0]         core_addr, core_wdata;

  op_e               op;
  mode_e             mode;
  logic [RSEL_W-1:0] rsel;
  logic [W-1:0]      reg_addr, operand, eff_addr, alu_res;
  logic              exec_en, active, store_wr, reg_wr, fetch_arg_en;

  assign op       = op_e'(ir_op_q[W-1 -: 3]);
  assign mode     = mode_e'(ir_op_q[W-4 -: 2]);
  assign rsel     = ir_op_q[RSEL_W-1:0];
  assign reg_addr = {{(W-RSEL_W){1'b0}}, rsel};

  assign rd_addr[RP_FETCH] = (state == ST_FETCH_ARG) ? pc + W'(1) : pc;
  assign rd_addr[RP_ABS]   = ir_arg_q;
  assign rd_addr[RP_IND]   = rd_data[RP_ABS];
  assign rd_addr[RP_REG]   = reg_addr;
  assign rd_addr[RP_DBG]   = dbg_addr;

  memreg_cpu_mem #(.W(W), .NRD(NRD)) u_mem (
    .clk        (clk),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .pc         (pc)
  );

  memreg_cpu_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run_en  (run_en),
    .halt_op (op == OP_HALT),
    .state   (state)
  );

  // operand resolution
  always_comb begin
    unique case (mode)
      MD_ABS:  operand = rd_data[RP_ABS];
      MD_IND:  operand = rd_data[RP_IND];
      default: operand = ir_arg_q;
    endcase
    eff_addr = (mode == MD_IND) ? rd_data[RP_ABS] : ir_arg_q;
  end

  memreg_cpu_alu #(.W(W)) u_alu (
    .op  (op),
    .lhs (rd_data[RP_REG]),
    .rhs (operand),
    .res (alu_res)
  );

  assign fetch_arg_en = run_en && (state == ST_FETCH_ARG);
  assign exec_en      = run_en && (state == ST_EXEC);
  assign active       = exec_en && (op != OP_HALT) && !(mode == MD_COND && !flag_q);
  assign store_wr     = active && (op == OP_STORE) && (mode == MD_ABS || mode == MD_IND);
  assign reg_wr       = active && (op != OP_STORE);

  // single core write port: PC advance, store, or register result
  always_comb begin
    core_we    = fetch_arg_en || store_wr || reg_wr;
    core_addr  = '0;
    core_wdata = pc + W'(2);
    if (store_wr) begin
      core_addr  = eff_addr;
      core_wdata = rd_data[RP_REG];
    end else if (reg_wr) begin
      core_addr  = reg_addr;
      core_wdata = alu_res;
    end
  end

  always_comb begin
    ir_op_nx  = ir_op_q;
    ir_arg_nx = ir_arg_q;
    flag_nx   = flag_q;
    if (run_en && state == ST_FETCH_OP) ir_op_nx  = rd_data[RP_FETCH];
    if (fetch_arg_en)                   ir_arg_nx = rd_data[RP_FETCH];
    if (reg_wr)                         flag_nx   = (alu_res == '0);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ir_op_q  <= '0;
      ir_arg_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      ir_op_q  <= ir_op_nx;
      ir_arg_q <= ir_arg_nx;
      flag_q   <= flag_nx;
    end
  end

  assign halted    = (state == ST_HALT);
  assign dbg_rdata = rd_data[RP_DBG];

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (fetch_arg_en && !host_we) |=> pc == W'($past(pc) + W'(2))); // R3

  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_wr && !host_we) |=> flag_q == (rd_data[RP_REG] == '0)); // R9

  AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_core_n)
    (exec_en && op == OP_STORE) |=> $stable(flag_q)); // R10

  AST_COND_SKIP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (exec_en && mode == MD_COND && !flag_q) |=> $stable(flag_q)); // R8

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |=> halted); // R12

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (halted && !host_we) |=> $stable(pc)); // R12

  AST_IDLE_PC: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!run_en && !host_we) |=> $stable(pc)); // R2

endmodule

// File: tb/memreg_cpu_tb.sv
module memreg_cpu_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       run_en;
  logic       halted;
  logic       host_we;
  logic [7:0] host_addr, host_wdata, dbg_addr, dbg_rdata;

  int checks = 0;
  int errors = 0;

  int m_mem [256];
  int m_flag, m_phase, m_halt, m_ir0, m_ir1;

  always #10 clk = ~clk;

  memreg_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .halted(halted),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: one active clock edge
  task automatic model_step();
    int op, md, r, opnd, ea, res, act;
    if (m_halt) return;
    case (m_phase)
      0: begin m_ir0 = m_mem[m_mem[0]]; m_phase = 1; end
      1: begin
        m_ir1 = m_mem[(m_mem[0] + 1) % 256];
        m_mem[0] = (m_mem[0] + 2) % 256;
        m_phase = 2;
      end
      default: begin
        m_phase = 0;
        op = m_ir0 / 32; md = (m_ir0 / 8) % 4; r = m_ir0 % 8;
        if (op == 7) m_halt = 1;
        else begin
          act = !(md == 3 && m_flag == 0);
          ea = (md == 2) ? m_mem[m_ir1] : m_ir1;
          opnd = (md == 1 || md == 2) ? m_mem[ea] : m_ir1;
          if (act && op == 1) begin
            if (md == 1 || md == 2) m_mem[ea] = m_mem[r];
          end else if (act) begin
            case (op)
              0: res = opnd;
              2: res = (m_mem[r] + opnd) % 256;
              3: res = (m_mem[r] - opnd + 256) % 256;
              4: res = m_mem[r] & opnd;
              5: res = m_mem[r] | opnd;
              default: res = m_mem[r] ^ opnd;
            endcase
            m_mem[r] = res;
            m_flag = (res == 0);
          end
        end
      end
    endcase
  endtask

  task automatic host_write(input int a, input int d);
    host_we = 1'b1; host_addr = 8'(a); host_wdata = 8'(d);
    @(posedge clk); @(negedge clk);
    host_we = 1'b0;
    m_mem[a] = d;
  endtask

  task automatic do_reset();
    run_en = 1'b0; host_we = 1'b0; dbg_addr = 8'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_flag = 0; m_phase = 0; m_halt = 0;
    chk("R1 halted after reset", int'(halted), 0);
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) host_write(a, 0);
  endtask

  // one clock with compare against the model every cycle
  task automatic tick(input bit en);
    run_en = en; dbg_addr = 8'd0;
    @(posedge clk); @(negedge clk);
    if (en) model_step();
    chk("R3 pc per cycle", int'(dbg_rdata), m_mem[0]);
    chk("R12 halted per cycle", int'(halted), m_halt);
  endtask

  task automatic run_to_halt(input bit pauses);
    int n = 0;
    while (!(m_halt && halted) && n < 400) begin
      tick(!(pauses && (n % 7 == 3 || n % 7 == 4)));
      n++;
    end
    if (n >= 400) chk("R12 halt reached", 0, 1);
  endtask

  task automatic sweep(input string tag);
    run_en = 1'b0;
    for (int a = 0; a < 256; a++) begin
      dbg_addr = 8'(a);
      #1;
      chk(tag, int'(dbg_rdata), m_mem[a]);
    end
    dbg_addr = 8'd0;
    #1;
  endtask

  task automatic peek(input string req, input int a, input int exp);
    dbg_addr = 8'(a);
    #1;
    chk(req, int'(dbg_rdata), exp);
    dbg_addr = 8'd0;
    #1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    do_reset();
    clear_mem();
    // program 1 at address 8
    host_write(0, 8);
    host_write(8,  8'h01); host_write(9,  8'hF0);  // LOAD r1 imm      R5
    host_write(10, 8'h41); host_write(11, 8'h20);  // ADD r1 imm wrap  R9
    host_write(12, 8'h69); host_write(13, 8'h80);  // SUB r1 abs       R6
    host_write(14, 8'h91); host_write(15, 8'h81);  // AND r1 ind       R7
    host_write(16, 8'hA2); host_write(17, 8'h30);  // OR r2
    host_write(18, 8'hC2); host_write(19, 8'h30);  // XOR r2 -> zero
    host_write(20, 8'h29); host_write(21, 8'h90);  // STORE r1 abs     R10
    host_write(22, 8'h31); host_write(23, 8'h81);  // STORE r1 ind
    host_write(24, 8'h21); host_write(25, 8'h00);  // STORE imm no-op
    host_write(26, 8'h1B); host_write(27, 8'h77);  // LOAD r3 cond taken R8
    host_write(28, 8'h1C); host_write(29, 8'h55);  // LOAD r4 cond skipped
    host_write(30, 8'h00); host_write(31, 8'd34);  // jump via r0      R11
    host_write(32, 8'hE0);
    host_write(34, 8'h65); host_write(35, 8'h01);  // SUB r5 wrap
    host_write(36, 8'h0E); host_write(37, 8'h05);  // LOAD r6 abs 5 (register)
    host_write(38, 8'h40); host_write(39, 8'h02);  // ADD r0 relative  R11
    host_write(40, 8'hE0);
    host_write(42, 8'hC7); host_write(43, 8'h00);  // XOR r7 -> flag set
    host_write(44, 8'hE0);                         // halt R12
    host_write(8'h80, 8'h05); host_write(8'h81, 8'h82); host_write(8'h82, 8'h0F);
    // R2: stalled core changes nothing
    for (int i = 0; i < 5; i++) tick(1'b0);
    chk("R2 pc held while stalled", int'(dbg_rdata), 8);
    run_to_halt(1'b1);
    peek("R9 r1 result", 1, 8'h0B);
    peek("R9 r2 xor zero", 2, 8'h00);
    peek("R8 cond taken r3", 3, 8'h77);
    peek("R8 cond skipped r4", 4, 8'h00);
    peek("R9 sub wrap r5", 5, 8'hFF);
    peek("R6 abs reads register", 6, 8'hFF);
    peek("R10 store abs", 8'h90, 8'h0B);
    peek("R7 R10 store ind", 8'h82, 8'h0B);
    peek("R11 R12 final pc", 0, 46);
    for (int i = 0; i < 6; i++) tick(1'b1);
    chk("R12 pc frozen after halt", int'(dbg_rdata), 46);
    sweep("R13 memory sweep prog1");

    // program 2: flag cleared by reset, conditional skipped
    do_reset();
    chk("R1 memory kept over reset", int'(dbg_rdata), 46);
    clear_mem();
    host_write(0, 8);
    host_write(8, 8'h19); host_write(9, 8'h99);    // LOAD r1 cond
    host_write(10, 8'hE0);
    run_to_halt(1'b0);
    peek("R1 R8 flag clear skips cond", 1, 8'h00);
    peek("R3 pc after two instr", 0, 12);
    // R13: host write wins, debug port reads it back
    host_write(8'hFF, 8'hA5);
    peek("R13 host write", 8'hFF, 8'hA5);
    sweep("R13 memory sweep prog2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule